// File: doc/BRIEF.md
# Outbound Address Translation Table

This block turns an address issued by a local memory-mapped requester into a wide PCIe address. The address bits above a fixed pass-through field pick one page from a small table that software can rewrite at any time. The chosen page supplies the upper bits of the outgoing address. The pass-through field is copied unchanged into the lowest bits. Each page also holds a 2-bit code that says which address space the outgoing request targets, and this code leaves the block together with the address.

A request is one cycle of `req_valid` with `req_addr`. The result appears on the next clock, qualified by `rsp_valid`. The table is loaded through its own write-only port, one 32-bit word per cycle. Each page occupies two word offsets. The low word carries the page's address bits from bit 31 down to the pass-through boundary, and its two lowest bits carry the space code. Those two bits lie inside the pass-through field and would otherwise be unused. The high word carries the address bits above bit 31. With the default parameters there are 12 pass-through bits, a 16-bit local address, 16 pages and a 64-bit PCIe address.

Top module: `ott_xlate_top`

## Requirements
- R1: After reset every page holds all-zero address bits and space code 2'b00, and `rsp_valid` and `rsp_err` are low until a request is made.
- R2: `rsp_valid` is high in exactly the cycles that follow a cycle in which `req_valid` was high, so there is one clock of latency and back-to-back requests stream one per cycle.
- R3: `rsp_addr[11:0]` equals `req_addr[11:0]` of the request being answered.
- R4: `req_addr[15:12]` selects the page, and `rsp_addr[63:12]` equals that page's stored address bits.
- R5: A write with `cfg_wr_addr[0]`=0 to page `cfg_wr_addr[4:1]` loads PCIe bits [31:12] from `cfg_wr_data[31:12]` and the space code from `cfg_wr_data[1:0]`. `cfg_wr_data[11:2]` is ignored.
- R6: A write with `cfg_wr_addr[0]`=1 loads PCIe bits [63:32] of the page from `cfg_wr_data[31:0]` and leaves the page's low bits and space code unchanged.
- R7: `rsp_space` gives the selected page's space code, where 2'b00 is 32-bit memory and 2'b01 is 64-bit memory.
- R8: `rsp_err` is high with `rsp_valid` when the selected page's code is reserved (2'b10 or 2'b11), and low otherwise.
- R9: When a write and a lookup hit the same page in the same cycle, the lookup returns the page's contents from before the write, and the next lookup returns the new contents.
- R10: A write changes only the page it addresses; every other page keeps its contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Lookup request strobe |
| req_addr | input | 16 | Local address to translate |
| cfg_wr_en | input | 1 | Table write strobe |
| cfg_wr_addr | input | 5 | Word offset: bits [4:1] select the page, bit 0 selects the high word |
| cfg_wr_data | input | 32 | Table write data |
| rsp_valid | output | 1 | Translated result valid |
| rsp_addr | output | 64 | Translated PCIe address |
| rsp_space | output | 2 | Space code of the selected page |
| rsp_err | output | 1 | Selected page holds a reserved space code |

## Verification
The hardest case to reach from the ports is a write and a lookup landing on the same page in the same clock. In that case the block must show the page as it was before the write. The stimulus first loads a known value into a page. In a single cycle it then raises `cfg_wr_en` and `req_valid`, both aimed at that page with a different value. It checks that the response carries the old value, and it checks that the following lookup carries the new one. A streaming sweep also covers back-to-back lookups across a permuted order of pages. The reserved codes are reached by programming them through the low-word write.

// File: rtl/ott_pkg.sv
package ott_pkg;

   typedef enum logic [1:0] {
      SPC_MEM32 = 2'b00,
      SPC_MEM64 = 2'b01,
      SPC_RSV2  = 2'b10,
      SPC_RSV3  = 2'b11
   } space_e;

   localparam int CFG_DW = 32;

   function automatic logic space_reserved(input logic [1:0] code);
      return (code == SPC_RSV2) || (code == SPC_RSV3);
   endfunction

endpackage

// File: rtl/ott_entry_bank.sv
module ott_entry_bank
   import ott_pkg::*;
#(
   parameter int N    = 12,
   parameter int P    = 64,
   parameter int IDXW = 4,
   localparam int Q     = 1 << IDXW,
   localparam int LO_W  = CFG_DW - N,
   localparam int HI_W  = P - CFG_DW,
   localparam int ENT_W = P - N
)(
   input  logic                         clk,
   input  logic                         rst,
   input  logic                         wr_en,
   input  logic [IDXW:0]                wr_addr,
   input  logic [CFG_DW-1:0]            wr_data,
   output logic [Q-1:0][ENT_W-1:0]      ent_q,
   output logic [Q-1:0][1:0]            sp_q
);

   logic [HI_W-1:0] hi_field;
   logic [LO_W-1:0] lo_field;
   logic            is_hi_word;
   logic [IDXW-1:0] wr_page;
   logic            unused_gap;

   assign lo_field   = wr_data[CFG_DW-1:N];
   assign is_hi_word = wr_addr[0];
   assign wr_page    = wr_addr[IDXW:1];
   assign unused_gap = ^wr_data[N-1:2];

   generate
      if (HI_W == CFG_DW) begin : g_hi_full
         assign hi_field = wr_data;
      end else begin : g_hi_part
         logic unused_hi_top;
         assign hi_field      = wr_data[HI_W-1:0];
         assign unused_hi_top = ^wr_data[CFG_DW-1:HI_W];
      end
   endgenerate

   generate
      for (genvar e = 0; e < Q; e++) begin : g_page
         logic hit;
         assign hit = wr_en && (wr_page == IDXW'(e));

         always_ff @(posedge clk) begin
            if (rst) begin
               ent_q[e] <= '0;
               sp_q[e]  <= SPC_MEM32;
            end else if (hit) begin
               if (!is_hi_word) begin
                  ent_q[e][LO_W-1:0] <= lo_field;
                  sp_q[e]            <= wr_data[1:0];
               end else begin
                  ent_q[e][ENT_W-1:LO_W] <= hi_field;
               end
            end
         end
      end
   endgenerate

endmodule

// File: rtl/ott_lookup.sv
module ott_lookup #(
   parameter int N    = 12,
   parameter int P    = 64,
   parameter int IDXW = 4,
   localparam int Q     = 1 << IDXW,
   localparam int ENT_W = P - N
)(
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    req_valid,
   input  logic [IDXW-1:0]         req_idx,
   input  logic [N-1:0]            req_low,
   input  logic [Q-1:0][ENT_W-1:0] ent_q,
   input  logic [Q-1:0][1:0]       sp_q,
   output logic                    vld_q,
   output logic [ENT_W-1:0]        ent_sel_q,
   output logic [1:0]              sp_sel_q,
   output logic [N-1:0]            low_q
);

   logic [ENT_W-1:0] ent_mux;
   logic [1:0]       sp_mux;

   always_comb begin
      ent_mux = ent_q[req_idx];
      sp_mux  = sp_q[req_idx];
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         vld_q     <= 1'b0;
         ent_sel_q <= '0;
         sp_sel_q  <= '0;
         low_q     <= '0;
      end else begin
         vld_q <= req_valid;
         if (req_valid) begin
            ent_sel_q <= ent_mux;
            sp_sel_q  <= sp_mux;
            low_q     <= req_low;
         end
      end
   end

endmodule

// File: rtl/ott_compose.sv
module ott_compose
   import ott_pkg::*;
#(
   parameter int N = 12,
   parameter int P = 64,
   localparam int ENT_W = P - N
)(
   input  logic             vld_q,
   input  logic [ENT_W-1:0] ent_sel_q,
   input  logic [1:0]       sp_sel_q,
   input  logic [N-1:0]     low_q,
   output logic [P-1:0]     out_addr,
   output logic [1:0]       out_space,
   output logic             out_err
);

   always_comb begin
      out_addr  = {ent_sel_q, low_q};
      out_space = sp_sel_q;
      out_err   = vld_q && space_reserved(sp_sel_q);
   end

endmodule

// File: rtl/ott_xlate_top.sv
module ott_xlate_top
   import ott_pkg::*;
#(
   parameter int PASS_W  = 12,
   parameter int SLV_AW  = 16,
   parameter int PCIE_AW = 64,
   localparam int IDX_W  = SLV_AW - PASS_W,
   localparam int ENT_W  = PCIE_AW - PASS_W
)(
   input  logic                clk,
   input  logic                rst,
   input  logic                req_valid,
   input  logic [SLV_AW-1:0]   req_addr,
   input  logic                cfg_wr_en,
   input  logic [IDX_W:0]      cfg_wr_addr,
   input  logic [CFG_DW-1:0]   cfg_wr_data,
   output logic                rsp_valid,
   output logic [PCIE_AW-1:0]  rsp_addr,
   output logic [1:0]          rsp_space,
   output logic                rsp_err
);

   localparam int Q = 1 << IDX_W;

   generate
      if (PASS_W < 2 || PASS_W >= CFG_DW) begin : g_bad_pass
         $error("PASS_W must leave room for the space code and stay below 32");
      end
      if (SLV_AW <= PASS_W) begin : g_bad_slv
         $error("SLV_AW must exceed PASS_W");
      end
      if (PCIE_AW <= CFG_DW || PCIE_AW > 2 * CFG_DW) begin : g_bad_pcie
         $error("PCIE_AW must lie in 33..64");
      end
      if (IDX_W > 8) begin : g_bad_depth
         $error("table depth above 256 pages is not supported");
      end
   endgenerate

   logic [Q-1:0][ENT_W-1:0] ent_q;
   logic [Q-1:0][1:0]       sp_q;
   logic                    vld_q;
   logic [ENT_W-1:0]        ent_sel_q;
   logic [1:0]              sp_sel_q;
   logic [PASS_W-1:0]       low_q;

   ott_entry_bank #(
      .N    (PASS_W),
      .P    (PCIE_AW),
      .IDXW (IDX_W)
   ) i_bank (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (cfg_wr_en),
      .wr_addr (cfg_wr_addr),
      .wr_data (cfg_wr_data),
      .ent_q   (ent_q),
      .sp_q    (sp_q)
   );

   ott_lookup #(
      .N    (PASS_W),
      .P    (PCIE_AW),
      .IDXW (IDX_W)
   ) i_lookup (
      .clk       (clk),
      .rst       (rst),
      .req_valid (req_valid),
      .req_idx   (req_addr[SLV_AW-1:PASS_W]),
      .req_low   (req_addr[PASS_W-1:0]),
      .ent_q     (ent_q),
      .sp_q      (sp_q),
      .vld_q     (vld_q),
      .ent_sel_q (ent_sel_q),
      .sp_sel_q  (sp_sel_q),
      .low_q     (low_q)
   );

   ott_compose #(
      .N (PASS_W),
      .P (PCIE_AW)
   ) i_compose (
      .vld_q     (vld_q),
      .ent_sel_q (ent_sel_q),
      .sp_sel_q  (sp_sel_q),
      .low_q     (low_q),
      .out_addr  (rsp_addr),
      .out_space (rsp_space),
      .out_err   (rsp_err)
   );

   assign rsp_valid = vld_q;

endmodule

// File: rtl/ott_xlate_chk.sv
module ott_xlate_chk #(
   parameter int N = 12,
   parameter int P = 64
)(
   input logic         clk,
   input logic         rst,
   input logic         req_valid,
   input logic [N-1:0] req_low,
   input logic         rsp_valid,
   input logic [N-1:0] rsp_low,
   input logic [1:0]   rsp_space,
   input logic         rsp_err
);

   AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
      req_valid |=> rsp_valid); // R2

   AST_VALID_IDLE: assert property (@(posedge clk) disable iff (rst)
      !req_valid |=> !rsp_valid); // R2

   AST_LOW_PASS: assert property (@(posedge clk) disable iff (rst)
      req_valid |=> (rsp_low == $past(req_low))); // R3

   AST_ERR_QUALIFIED: assert property (@(posedge clk) disable iff (rst)
      rsp_err |-> rsp_valid); // R8

   AST_ERR_ON_RESERVED: assert property (@(posedge clk) disable iff (rst)
      rsp_valid |-> (rsp_err == rsp_space[1])); // R8

endmodule

bind ott_xlate_top ott_xlate_chk #(
   .N (PASS_W),
   .P (PCIE_AW)
) i_chk (
   .clk       (clk),
   .rst       (rst),
   .req_valid (req_valid),
   .req_low   (req_addr[PASS_W-1:0]),
   .rsp_valid (rsp_valid),
   .rsp_low   (rsp_addr[PASS_W-1:0]),
   .rsp_space (rsp_space),
   .rsp_err   (rsp_err)
);

// File: tb/test_ott_xlate_top.sv
module test_ott_xlate_top;

   localparam int CLK_PERIOD = 10;
   localparam int N  = 12;
   localparam int M  = 16;
   localparam int P  = 64;
   localparam int IW = M - N;
   localparam int Q  = 1 << IW;
   localparam int EW = P - N;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          req_valid = 1'b0;
   logic [M-1:0]  req_addr = '0;
   logic          cfg_wr_en = 1'b0;
   logic [IW:0]   cfg_wr_addr = '0;
   logic [31:0]   cfg_wr_data = '0;
   logic          rsp_valid;
   logic [P-1:0]  rsp_addr;
   logic [1:0]    rsp_space;
   logic          rsp_err;

   int n_vec = 0;
   int n_bad = 0;
   logic [EW-1:0] m_ent [Q];
   logic [1:0]    m_sp  [Q];

   ott_xlate_top i_ott_xlate_top (
      .clk         (clk),
      .rst         (rst),
      .req_valid   (req_valid),
      .req_addr    (req_addr),
      .cfg_wr_en   (cfg_wr_en),
      .cfg_wr_addr (cfg_wr_addr),
      .cfg_wr_data (cfg_wr_data),
      .rsp_valid   (rsp_valid),
      .rsp_addr    (rsp_addr),
      .rsp_space   (rsp_space),
      .rsp_err     (rsp_err)
   );

   always #(CLK_PERIOD / 2) clk = ~clk;

   task automatic chk(input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic model_write(input int idx, input bit hi, input logic [31:0] d);
      if (!hi) begin
         m_ent[idx][31-N:0] = d[31:N];
         m_sp[idx]          = d[1:0];
      end else begin
         m_ent[idx][EW-1:32-N] = d[P-33:0];
      end
   endtask

   task automatic cfg_write(input int idx, input bit hi, input logic [31:0] d);
      @(negedge clk);
      cfg_wr_en   = 1'b1;
      cfg_wr_addr = {IW'(idx), hi};
      cfg_wr_data = d;
      @(negedge clk);
      cfg_wr_en = 1'b0;
      model_write(idx, hi, d);
   endtask

   task automatic check_rsp(input string req, input int idx, input logic [N-1:0] low,
                            input logic [EW-1:0] ent, input logic [1:0] sp);
      chk(req, "valid", 64'(rsp_valid), 64'd1);
      chk(req, "addr", rsp_addr, {ent, low});
      chk(req, "space", 64'(rsp_space), 64'(sp));
      chk(req, "err", 64'(rsp_err), 64'(sp[1]));
   endtask

   task automatic look(input string req, input int idx, input logic [N-1:0] low);
      @(negedge clk);
      req_valid = 1'b1;
      req_addr  = {IW'(idx), low};
      @(negedge clk);
      req_valid = 1'b0;
      check_rsp(req, idx, low, m_ent[idx], m_sp[idx]);
   endtask

   task automatic t_reset;
      chk("R1", "valid after reset", 64'(rsp_valid), 64'd0);
      chk("R1", "err after reset", 64'(rsp_err), 64'd0);
      for (int i = 0; i < Q; i++) look("R1", i, N'(i * 37 + 5));
      @(negedge clk);
      chk("R2", "valid idle", 64'(rsp_valid), 64'd0);
   endtask

   task automatic t_low_word;
      cfg_write(3, 1'b0, 32'hABCDE_FFD);
      look("R5", 3, 12'h5A5);
      chk("R7", "64-bit code", 64'(rsp_space), 64'd1);
      chk("R3", "low pass", 64'(rsp_addr[N-1:0]), 64'h5A5);
   endtask

   task automatic t_high_word;
      cfg_write(3, 1'b1, 32'h1234_5678);
      look("R6", 3, 12'h0F0);
      chk("R6", "low bits kept", 64'(rsp_addr[31:N]), 64'hABCDE);
      chk("R6", "space kept", 64'(rsp_space), 64'd1);
   endtask

   task automatic t_isolation;
      look("R10", 2, 12'h001);
      chk("R10", "page 2 upper", rsp_addr[P-1:N], 64'd0);
      look("R10", 4, 12'hFFF);
      chk("R10", "page 4 upper", rsp_addr[P-1:N], 64'd0);
   endtask

   task automatic t_reserved;
      cfg_write(7, 1'b0, 32'h0000_1002);
      look("R8", 7, 12'h123);
      chk("R8", "err code 10", 64'(rsp_err), 64'd1);
      cfg_write(7, 1'b0, 32'h0000_2003);
      look("R8", 7, 12'h456);
      chk("R8", "err code 11", 64'(rsp_err), 64'd1);
      cfg_write(7, 1'b0, 32'h0000_3000);
      look("R8", 7, 12'h789);
      chk("R8", "no err code 00", 64'(rsp_err), 64'd0);
      chk("R7", "32-bit code", 64'(rsp_space), 64'd0);
   endtask

   task automatic t_collide;
      logic [EW-1:0] old_ent;
      logic [1:0]    old_sp;
      cfg_write(5, 1'b0, 32'h1111_1001);
      cfg_write(5, 1'b1, 32'h2222_2222);
      old_ent = m_ent[5];
      old_sp  = m_sp[5];
      @(negedge clk);
      cfg_wr_en   = 1'b1;
      cfg_wr_addr = {IW'(5), 1'b0};
      cfg_wr_data = 32'h99999_002;
      req_valid   = 1'b1;
      req_addr    = {IW'(5), 12'h3C3};
      @(negedge clk);
      cfg_wr_en = 1'b0;
      req_valid = 1'b0;
      check_rsp("R9", 5, 12'h3C3, old_ent, old_sp);
      model_write(5, 1'b0, 32'h99999_002);
      look("R9", 5, 12'h3C4);
      chk("R9", "new low bits", 64'(rsp_addr[31:N]), 64'h99999);
   endtask

   task automatic t_sweep;
      int            prev_idx;
      logic [N-1:0]  prev_low;
      for (int i = 0; i < Q; i++) begin
         cfg_write(i, 1'b0, {20'(20'h0F00D ^ (i * 20'h01357)), 10'h0, 2'(i % 2)});
         cfg_write(i, 1'b1, 32'hC0DE_0000 | (i * 32'h0001_0203));
      end
      prev_idx = 0;
      prev_low = '0;
      for (int k = 0; k < Q; k++) begin
         @(negedge clk);
         if (k > 0) check_rsp("R4", prev_idx, prev_low, m_ent[prev_idx], m_sp[prev_idx]);
         prev_idx  = (k * 5 + 3) % Q;
         prev_low  = N'(k * 12'h111);
         req_valid = 1'b1;
         req_addr  = {IW'(prev_idx), prev_low};
      end
      @(negedge clk);
      req_valid = 1'b0;
      check_rsp("R2", prev_idx, prev_low, m_ent[prev_idx], m_sp[prev_idx]);
      @(negedge clk);
      chk("R2", "valid drops", 64'(rsp_valid), 64'd0);
   endtask

   initial begin
      #(CLK_PERIOD * 20000);
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      for (int i = 0; i < Q; i++) begin
         m_ent[i] = '0;
         m_sp[i]  = 2'b00;
      end
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      t_reset();
      t_low_word();
      t_high_word();
      t_isolation();
      t_reserved();
      t_collide();
      t_sweep();
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule